// File: doc/BRIEF.md
# Transport Stream Energy Dispersal Randomizer

This block whitens a byte-wide transport stream before it is sent over a line. The stream is made of fixed-length packets, 188 bytes by default. Each packet begins with a sync byte. Payload bytes are XORed with a pseudo-random sequence from a 15-stage shift register whose feedback polynomial is 1 + x^14 + x^15. This gives the line enough bit transitions for clock recovery at the far end.

Packets are handled in groups of eight. The sync byte that opens a group is replaced by its bitwise inverse, which tells a downstream descrambler where the group starts. At that byte the generator is reloaded with a fixed seed. The other seven sync bytes pass through unchanged, but the generator still steps through them. As a result, one full cycle of the sequence covers 1503 bytes.

Packet boundaries come from an input start strobe. When no strobe arrives, the block assumes a boundary every 188 bytes and keeps randomising. Every valid byte appears on the output exactly one clock later.

Top module: `ts_whitener`

## Requirements
- R1: While reset is held and just after it is released, out_valid, out_start and out_data are all zero.
- R2: out_valid equals in_valid delayed by exactly one clock cycle. The data and start outputs of a byte appear in that same cycle.
- R3: The first packet-start byte of each eight-packet group leaves as the bitwise inverse of the input byte. The sync value 0x47 becomes 0xB8.
- R4: Packet-start bytes of packets 2 to 8 of a group leave unchanged.
- R5: Every non-start byte is XORed with eight generator bits, taken MSB first: the first bit produced goes to bit 7. The generator is 1 + x^14 + x^15. Each step's output is stage 14 XOR stage 15, and that value also shifts into stage 1. For an all-zero payload, the first byte after an inverted sync therefore reads 0x03.
- R6: During the seven non-inverted sync bytes, the generator still advances by eight steps but its output is not applied. The sequence repeats every 1503 bytes.
- R7: A cycle with in_valid low advances neither the generator nor the packet counters, and out_data keeps its previous value.
- R8: With in_start held low, a new packet is assumed every 188 valid bytes, and groups and randomisation continue without stopping.
- R9: A valid byte with in_start high is always taken as byte 0 of a new packet, even in the middle of a packet. It advances the group packet count, and out_start is high one cycle later.
- R10: out_start is high exactly for output bytes that are packet-start bytes, whether flagged by the strobe or inferred, and only when out_valid is high.
- R11: At every group-opening sync byte the generator is reloaded with the seed. Stages 1 to 15 receive 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0. The first byte from reset is the first byte of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_start | input | 1 | Marks the input byte as the first byte of a packet |
| in_data | input | 8 | Input stream byte |
| out_valid | output | 1 | Output byte qualifier, one cycle after in_valid |
| out_start | output | 1 | Marks the output byte as a packet-start byte |
| out_data | output | 8 | Randomised byte |

## Verification
Suppose the group counter is wrong by one packet. Then the wrong sync byte is inverted, and the first payload byte that follows is XORed with a mask that is not 0x03. Both faults show at the output one cycle after that byte is accepted.

Suppose the generator state is wrong, for example a missed step during a masked sync byte or a step taken on an idle cycle. The error corrupts the very next payload byte and every byte after it until the next group reload, so at most about 1500 bytes later.

Suppose the position counter slips. The first misplaced packet start shows as a wrong out_start pulse and a sync byte that gets randomised instead of passed through.

// File: rtl/ts_whiten_pkg.sv
// Shared definitions for the transport stream randomizer.
// Assumes byte-wide processing; the kind enum classifies each accepted byte.
package ts_whiten_pkg;

    // Role of an accepted byte within the packet/group framing
    typedef enum logic [1:0] {
        KIND_PAYLOAD    = 2'd0,
        KIND_GROUP_SYNC = 2'd1,
        KIND_PLAIN_SYNC = 2'd2
    } byte_kind_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ts_pkt_tracker.sv
// Packet and group position tracker.
// Classifies each accepted byte as group-opening sync, plain sync or
// payload. A packet start is either strobed (start_in) or inferred when
// the byte counter wraps, so the block free-runs on unframed input.
// Assumes PKT_LEN >= 2 and GROUP_PKTS >= 2. Counters hold on idle cycles.
module ts_pkt_tracker #(
    parameter int PKT_LEN    = 188,
    parameter int GROUP_PKTS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_vld,
    input  logic                     start_in,
    output ts_whiten_pkg::byte_kind_e kind,
    output logic                     pkt_head
);
    import ts_whiten_pkg::*;

    localparam int POS_W = (PKT_LEN > 2) ? $clog2(PKT_LEN) : 1;
    localparam int GRP_W = (GROUP_PKTS > 2) ? $clog2(GROUP_PKTS) : 1;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_LEN - 1);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP_PKTS - 1);

    logic [POS_W-1:0] nxt_pos_q;
    logic [POS_W-1:0] cur_pos;
    logic [GRP_W-1:0] pkt_q;
    logic [GRP_W-1:0] cur_pkt;

    // Position and packet index of the byte currently on the input
    always_comb begin
        pkt_head = start_in || (nxt_pos_q == '0);
        cur_pos  = start_in ? '0 : nxt_pos_q;
        cur_pkt  = pkt_q;
        if (pkt_head) begin
            cur_pkt = (pkt_q == GRP_LAST) ? '0 : pkt_q + GRP_W'(1);
        end
    end

    // Classify the byte for the data path
    always_comb begin
        if (!pkt_head) begin
            kind = KIND_PAYLOAD;
        end else if (cur_pkt == '0) begin
            kind = KIND_GROUP_SYNC;
        end else begin
            kind = KIND_PLAIN_SYNC;
        end
    end

    // Advance counters on each accepted byte; reset makes the first byte open a group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_pos_q <= '0;
            pkt_q     <= GRP_LAST;
        end else if (byte_vld) begin
            nxt_pos_q <= (cur_pos == POS_LAST) ? '0 : cur_pos + POS_W'(1);
            pkt_q     <= cur_pkt;
        end
    end

endmodule

// File: rtl/ts_prbs_byte.sv
// Byte-parallel pseudo-random generator, two-tap Fibonacci form.
// Bit k-1 of state_q holds stage k. Each step: fb = stage TAP_A ^ stage
// TAP_B, shift toward higher stages, fb into stage 1. Eight (BYTE_W)
// steps are unrolled per advance; the first fb lands in the mask MSB.
// load has priority over advance and puts SEED into the register.
module ts_prbs_byte #(
    parameter int                  LFSR_LEN = 15,
    parameter int                  TAP_A    = 14,
    parameter int                  TAP_B    = 15,
    parameter int                  BYTE_W   = 8,
    parameter logic [LFSR_LEN-1:0] SEED     = 15'h00A9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    output logic [BYTE_W-1:0]   mask,
    output logic [LFSR_LEN-1:0] state_q
);
    logic [LFSR_LEN-1:0] chain [0:BYTE_W];
    logic [BYTE_W-1:0]   fb;

    assign chain[0] = state_q;

    // Unrolled single-bit steps, one per output bit
    for (genvar i = 0; i < BYTE_W; i++) begin : g_step
        assign fb[i]             = chain[i][TAP_A-1] ^ chain[i][TAP_B-1];
        assign chain[i+1]        = {chain[i][LFSR_LEN-2:0], fb[i]};
        assign mask[BYTE_W-1-i]  = fb[i];
    end

    // Register update: reload, step a byte, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= chain[BYTE_W];
        end
    end

endmodule

// File: rtl/ts_out_stage.sv
// Output register of the randomizer: applies inversion, pass-through or
// mask XOR according to byte kind, and delays valid/start by one cycle.
// Assumes mask is the generator byte for the current state. Data holds
// while no byte is accepted.
module ts_out_stage #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vld,
    input  logic                      head,
    input  ts_whiten_pkg::byte_kind_e kind,
    input  logic [BYTE_W-1:0]         din,
    input  logic [BYTE_W-1:0]         mask,
    output logic                      out_valid,
    output logic                      out_start,
    output logic [BYTE_W-1:0]         out_data
);
    import ts_whiten_pkg::*;

    logic [BYTE_W-1:0] next_byte;

    // Per-kind byte transform
    always_comb begin
        case (kind)
            KIND_GROUP_SYNC: next_byte = ~din;
            KIND_PLAIN_SYNC: next_byte = din;
            default:         next_byte = din ^ mask;
        endcase
    end

    // One-cycle output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_start <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= vld;
            out_start <= vld && head;
            if (vld) begin
                out_data <= next_byte;
            end
        end
    end

endmodule

// File: rtl/ts_whitener.sv
// Transport stream energy dispersal randomizer, top level.
// Tracks packet/group position, drives the byte-parallel generator
// (reload on group-opening sync, step on every other accepted byte) and
// registers the transformed byte. Fixed latency of one cycle.
// Assumes one byte per clock at most; framing strobe optional.
module ts_whitener #(
    parameter int                  PKT_LEN    = 188,
    parameter int                  GROUP_PKTS = 8,
    parameter int                  LFSR_LEN   = 15,
    parameter int                  TAP_A      = 14,
    parameter int                  TAP_B      = 15,
    parameter logic [LFSR_LEN-1:0] SEED       = 15'h00A9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic       out_start,
    output logic [7:0] out_data
);
    import ts_whiten_pkg::*;

    byte_kind_e          kind;
    logic                pkt_head;
    logic                first_sync;
    logic                plain_sync;
    logic [BYTE_W-1:0]   prbs_mask;
    logic [LFSR_LEN-1:0] lfsr_q;

    ts_pkt_tracker #(
        .PKT_LEN    (PKT_LEN),
        .GROUP_PKTS (GROUP_PKTS)
    ) tracker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (in_valid),
        .start_in (in_start),
        .kind     (kind),
        .pkt_head (pkt_head)
    );

    // Decode byte role for generator control
    always_comb begin
        first_sync = (kind == KIND_GROUP_SYNC);
        plain_sync = (kind == KIND_PLAIN_SYNC);
    end

    ts_prbs_byte #(
        .LFSR_LEN (LFSR_LEN),
        .TAP_A    (TAP_A),
        .TAP_B    (TAP_B),
        .BYTE_W   (BYTE_W),
        .SEED     (SEED)
    ) prbs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid && first_sync),
        .advance (in_valid && !first_sync),
        .mask    (prbs_mask),
        .state_q (lfsr_q)
    );

    ts_out_stage #(
        .BYTE_W (BYTE_W)
    ) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (in_valid),
        .head      (pkt_head),
        .kind      (kind),
        .din       (in_data),
        .mask      (prbs_mask),
        .out_valid (out_valid),
        .out_start (out_start),
        .out_data  (out_data)
    );

endmodule

// File: rtl/ts_whitener_chk.sv
// Property checker for ts_whitener, attached by bind below.
// Relates input bytes to registered outputs and generator state.
module ts_whitener_chk #(
    parameter int                  LFSR_LEN = 15,
    parameter logic [LFSR_LEN-1:0] SEED     = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_start,
    input logic [7:0]          in_data,
    input logic                out_valid,
    input logic                out_start,
    input logic [7:0]          out_data,
    input logic                first_sync,
    input logic                plain_sync,
    input logic [LFSR_LEN-1:0] lfsr_q
);
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> out_valid == $past(in_valid)); // R2
    AST_GROUP_SYNC_INV: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) && $past(in_valid && first_sync) |-> out_data == ~$past(in_data)); // R3
    AST_PLAIN_SYNC_PASS: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) && $past(in_valid && plain_sync) |-> out_data == $past(in_data)); // R4
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) && !$past(in_valid) |-> $stable(lfsr_q) && $stable(out_data)); // R7
    AST_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) && $past(in_valid && in_start) |-> out_start); // R9
    AST_START_QUAL: assert property (@(posedge clk) disable iff (!rst_n) out_start |-> out_valid); // R10
    AST_SEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) && $past(in_valid && first_sync) |-> lfsr_q == SEED); // R11
endmodule

bind ts_whitener ts_whitener_chk #(
    .LFSR_LEN (LFSR_LEN),
    .SEED     (SEED)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_start   (in_start),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_start  (out_start),
    .out_data   (out_data),
    .first_sync (first_sync),
    .plain_sync (plain_sync),
    .lfsr_q     (lfsr_q)
);

// File: tb/ts_whitener_tb_top.sv
// Self-checking bench: bit-serial reference model, every output byte compared.
module ts_whitener_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_LEN    = 188;
    localparam int GROUP_PKTS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_start;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    bit         stg [1:15];
    int         m_pos = 0;
    int         m_pkt = GROUP_PKTS - 1;
    int         gs_count = 0;
    bit         pend_gs = 1'b0;
    logic       exp_v = 1'b0;
    logic       exp_s = 1'b0;
    logic [7:0] exp_d = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_whitener dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_start (out_start),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic seed_load();
        stg = '{1,0,0,1,0,1,0,1,0,0,0,0,0,0,0};
    endtask

    task automatic next_mask(output logic [7:0] m);
        m = 8'h00;
        for (int b = 0; b < 8; b++) begin
            bit nb;
            nb = stg[14] ^ stg[15];
            for (int k = 15; k > 1; k--) stg[k] = stg[k-1];
            stg[1] = nb;
            m = {m[6:0], nb};
        end
    endtask

    // Drive one cycle, update model, check registered result a quarter period after the edge
    task automatic push(input logic v, input logic st, input logic [7:0] d, input string tag);
        string t;
        logic [7:0] mk;
        bit gs_check;
        int gs_idx;
        gs_check = 1'b0;
        gs_idx = 0;
        in_valid = v; in_start = st; in_data = d;
        if (v) begin
            bit head;
            int pos;
            head = st || (m_pos == 0);
            pos  = st ? 0 : m_pos;
            if (head) m_pkt = (m_pkt + 1) % GROUP_PKTS;
            exp_v = 1'b1;
            exp_s = head;
            if (head && m_pkt == 0) begin
                exp_d = ~d; seed_load(); t = "R3";
                gs_count++; pend_gs = 1'b1;
            end else if (head) begin
                next_mask(mk); exp_d = d; t = "R4"; pend_gs = 1'b0;
            end else begin
                next_mask(mk); exp_d = d ^ mk;
                t = (m_pkt == 0) ? "R5" : "R6";
                if (pend_gs && d == 8'h00) begin gs_check = 1'b1; gs_idx = gs_count; end
                pend_gs = 1'b0;
            end
            m_pos = (pos + 1) % PKT_LEN;
            if (tag != "") t = tag;
        end else begin
            exp_v = 1'b0; exp_s = 1'b0; t = "R7";
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(out_valid == exp_v, "R2", {7'd0, out_valid}, {7'd0, exp_v});
        chk(out_start == exp_s, "R10", {7'd0, out_start}, {7'd0, exp_s});
        chk(out_data == exp_d, t, out_data, exp_d);
        if (gs_check) chk(out_data == 8'h03, (gs_idx == 1) ? "R5" : "R11", out_data, 8'h03);
    endtask

    // Watchdog: hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        seed_load();
        repeat (4) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", {7'd0, out_valid}, 8'h00);
        chk(out_start == 1'b0, "R1", {7'd0, out_start}, 8'h00);
        chk(out_data == 8'h00, "R1", out_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(out_valid == 1'b0, "R1", {7'd0, out_valid}, 8'h00);
        chk(out_data == 8'h00, "R1", out_data, 8'h00);

        // R8/R5/R11: free-running, zero data, no strobes: output is the raw sequence
        for (int i = 0; i < 17 * PKT_LEN; i++) push(1'b1, 1'b0, 8'h00, "R8");

        // R3/R4/R5/R6: framed stream, two full groups
        for (int p = 0; p < 16; p++)
            for (int q = 0; q < PKT_LEN; q++)
                push(1'b1, q == 0, (q == 0) ? 8'h47 : 8'((q * 13 + p * 5) & 255), "");

        // R7: framed stream with idle gaps every fourth cycle
        for (int p = 0; p < 9; p++)
            for (int q = 0; q < PKT_LEN; q++) begin
                if (q % 4 == 3) push(1'b0, 1'b0, 8'hA5, "");
                push(1'b1, q == 0, (q == 0) ? 8'h47 : 8'((q * 37 + 11) & 255), "");
            end

        // R9: strobe in the middle of a packet resynchronises
        for (int q = 0; q < 60; q++) push(1'b1, q == 0, (q == 0) ? 8'h47 : 8'(q), "");
        for (int p = 0; p < 3; p++)
            for (int q = 0; q < PKT_LEN; q++)
                push(1'b1, q == 0, (q == 0) ? 8'h47 : 8'(q ^ 8'h5A), (q == 0 && p == 0) ? "R9" : "");
        for (int q = 0; q < 3 * PKT_LEN; q++) push(1'b1, 1'b0, 8'((q * 3) & 255), "R8");
        push(1'b0, 1'b0, 8'h00, "");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule